// File: doc/BRIEF.md
# Cross-Domain Mailbox Register Pair

This block holds two single-word mailboxes that let two independently clocked ports hand words to each other without going through the main queue. The first mailbox carries a word from port A to port B. The second carries a word from port B to port A. Each port decides per access whether it touches a mailbox or the queue. It does this with a mailbox-select input, qualified by an active-low chip select, an active-high enable and a write/read select, all sampled on the rising edge of that port's clock.

Each mailbox has an active-low "mail waiting" flag. The flag is output in the writer's clock domain. A qualified mailbox write drops the flag and captures the word. Further writes are refused until the opposite port reads the mailbox. That read is carried back across the clock boundary, and only then does the flag rise again.

Internally every mailbox is one channel made of two small state machines:
- Writer machine, states `W_EMPTY` and `W_HELD`:
  - transition "load": `W_EMPTY` to `W_HELD` on a qualified write. It captures the word and toggles a request bit.
  - transition "release": `W_HELD` to `W_EMPTY` once the synchronized acknowledge equals the request.
- Reader machine, states `R_IDLE` and `R_PEND`:
  - transition "notice": `R_IDLE` to `R_PEND` when the synchronized request differs from the acknowledge.
  - transition "take": `R_PEND` to `R_IDLE` on a qualified mailbox read. It toggles the acknowledge.

On port B the mailbox select also steers the output: the mailbox word or the word presented by the queue's output register.

Top module: `xdom_mailbox`

## Requirements
- R1: After reset both flags (`m1_flag_n`, `m2_flag_n`) are 1, and both mailbox words read as zero (`b_dout` with `b_mb`=1, and `a_dout`).
- R2: A port-A rising edge with `a_cs_n`=0, `a_en`=1, `a_wr`=1, `a_mb`=1 while `m1_flag_n`=1 stores `a_din` in mailbox 1 and drives `m1_flag_n` to 0 after that edge.
- R3: A port-A edge with any other combination of `a_cs_n`, `a_en`, `a_wr`, `a_mb` leaves `m1_flag_n` at 1 and the mailbox 1 word unchanged.
- R4: While `m1_flag_n`=0 a qualified port-A mailbox write is ignored: the stored word and the flag are unchanged.
- R5: A port-B edge with `b_cs_n`=0, `b_en`=1, `b_wr`=0, `b_mb`=1, once the pending mail has reached port B (at most 5 port-B cycles after the write), returns `m1_flag_n` to 1 within 8 port-A cycles.
- R6: A port-B mailbox read made while no mail is pending is ignored. A later write keeps `m1_flag_n` at 0 until a new read.
- R7: `b_dout` equals the mailbox 1 word when `b_mb`=1 and equals `b_fifo_q` when `b_mb`=0, independent of the other port-B inputs.
- R8: Mailbox 2 mirrors R2 to R5 with the ports swapped, on `m2_flag_n` in the port-B domain. A write needs `b_cs_n`=0, `b_en`=1, `b_wr`=1, `b_mb`=1. The word is visible on `a_dout`. The clear is an A read (`a_wr`=0, `a_mb`=1) that returns the flag to 1 within 8 port-B cycles.
- R9: Once low, a flag stays low on every writer edge until the reader's acknowledge arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_en | input | 1 | Port A enable |
| a_wr | input | 1 | Port A direction, 1 = write, 0 = read |
| a_mb | input | 1 | Port A mailbox select |
| a_din | input | W | Port A write data |
| a_dout | output | W | Mailbox 2 word for port A |
| m1_flag_n | output | 1 | Mailbox 1 mail-waiting flag, low active, port-A domain |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_en | input | 1 | Port B enable |
| b_wr | input | 1 | Port B direction, 1 = write, 0 = read |
| b_mb | input | 1 | Port B mailbox select and output steering |
| b_din | input | W | Port B write data |
| b_fifo_q | input | W | Queue output-register word |
| b_dout | output | W | Port B read data |
| m2_flag_n | output | 1 | Mailbox 2 mail-waiting flag, low active, port-B domain |

## Verification
The assertions assume that each port's controls are stable around its own rising edge. They also assume that the reader reads the stored word only while that mailbox is pending on its side. The bench changes every input at the falling edge of the owning port's clock. It reads a mailbox only after waiting five reader cycles past the write, so that the request has crossed the boundary. The sweeps try all sixteen combinations of the four access controls on each port, with distinct data words for each combination. They then probe the blocked write, the early read and the output steering.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic {
        W_EMPTY = 1'b0,
        W_HELD  = 1'b1
    } wr_state_e;

    typedef enum logic {
        R_IDLE = 1'b0,
        R_PEND = 1'b1
    } rd_state_e;

    localparam int NUM_CHANNELS = 2;

endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbox_access_dec.sv
module mbox_access_dec (
    input  logic cs_n,
    input  logic en,
    input  logic wr,
    input  logic mb,
    output logic mb_write,
    output logic mb_read
);
    logic active;

    always_comb begin
        active   = !cs_n && en && mb;
        mb_write = active && wr;
        mb_read  = active && !wr;
    end
endmodule

// File: rtl/mbox_writer.sv
module mbox_writer
    import mbox_pkg::*;
#(
    parameter int W           = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_fire,
    input  logic [W-1:0] din,
    input  logic         ack_tgl,
    output logic         req_tgl,
    output logic         flag_n,
    output logic [W-1:0] data_q
);
    wr_state_e st_q, st_d;
    logic      ack_s;
    logic      load;

    mbox_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    // next state and load strobe
    always_comb begin
        st_d = st_q;
        load = 1'b0;
        unique case (st_q)
            W_EMPTY: begin
                if (wr_fire) begin
                    st_d = W_HELD;
                    load = 1'b1;
                end
            end
            W_HELD: begin
                if (ack_s == req_tgl) st_d = W_EMPTY;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= W_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q  <= '0;
            req_tgl <= 1'b0;
        end else if (load) begin
            data_q  <= din;
            req_tgl <= ~req_tgl;
        end
    end

    assign flag_n = (st_q == W_EMPTY);

    // R2: accepted write drops the flag on the next edge
    p_set_on_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && flag_n) |=> !flag_n);

    // R4: stored word frozen while mail waits
    p_hold_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_n |=> $stable(data_q));

    // R9: flag stays low until acknowledge matches request
    p_hold_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_n && (ack_s != req_tgl)) |=> !flag_n);
endmodule

// File: rtl/mbox_reader.sv
module mbox_reader
    import mbox_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_fire,
    input  logic req_tgl,
    output logic ack_tgl
);
    rd_state_e st_q, st_d;
    logic      req_s;
    logic      take;

    mbox_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (req_tgl),
        .q     (req_s)
    );

    always_comb begin
        st_d = st_q;
        take = 1'b0;
        unique case (st_q)
            R_IDLE: begin
                if (req_s != ack_tgl) st_d = R_PEND;
            end
            R_PEND: begin
                if (rd_fire) begin
                    st_d = R_IDLE;
                    take = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= R_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ack_tgl <= 1'b0;
        else if (take) ack_tgl <= ~ack_tgl;
    end

    // R6: no acknowledge without pending mail
    p_ack_needs_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == R_IDLE) |=> $stable(ack_tgl));

    // R5: a read of pending mail sends the acknowledge
    p_read_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == R_PEND && rd_fire) |=> (ack_tgl != $past(ack_tgl)));
endmodule

// File: rtl/mbox_channel.sv
module mbox_channel #(
    parameter int W           = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         wclk,
    input  logic         rclk,
    input  logic         rst_n,
    input  logic         wr_fire,
    input  logic [W-1:0] din,
    input  logic         rd_fire,
    output logic         flag_n,
    output logic [W-1:0] data_q
);
    logic req_tgl;
    logic ack_tgl;

    mbox_writer #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_wr (
        .clk     (wclk),
        .rst_n   (rst_n),
        .wr_fire (wr_fire),
        .din     (din),
        .ack_tgl (ack_tgl),
        .req_tgl (req_tgl),
        .flag_n  (flag_n),
        .data_q  (data_q)
    );

    mbox_reader #(.SYNC_STAGES(SYNC_STAGES)) u_rd (
        .clk     (rclk),
        .rst_n   (rst_n),
        .rd_fire (rd_fire),
        .req_tgl (req_tgl),
        .ack_tgl (ack_tgl)
    );
endmodule

// File: rtl/xdom_mailbox.sv
module xdom_mailbox
    import mbox_pkg::*;
#(
    parameter int W           = 36,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         rst_n,
    input  logic         a_cs_n,
    input  logic         a_en,
    input  logic         a_wr,
    input  logic         a_mb,
    input  logic [W-1:0] a_din,
    output logic [W-1:0] a_dout,
    output logic         m1_flag_n,
    input  logic         b_cs_n,
    input  logic         b_en,
    input  logic         b_wr,
    input  logic         b_mb,
    input  logic [W-1:0] b_din,
    input  logic [W-1:0] b_fifo_q,
    output logic [W-1:0] b_dout,
    output logic         m2_flag_n
);
    logic a_mb_write, a_mb_read, b_mb_write, b_mb_read;

    mbox_access_dec u_dec_a (
        .cs_n(a_cs_n), .en(a_en), .wr(a_wr), .mb(a_mb),
        .mb_write(a_mb_write), .mb_read(a_mb_read)
    );

    mbox_access_dec u_dec_b (
        .cs_n(b_cs_n), .en(b_en), .wr(b_wr), .mb(b_mb),
        .mb_write(b_mb_write), .mb_read(b_mb_read)
    );

    // channel 0: A writes, B reads; channel 1: B writes, A reads
    logic [NUM_CHANNELS-1:0] ch_wclk, ch_rclk, ch_wfire, ch_rfire, ch_flag_n;
    logic [W-1:0]            ch_din  [NUM_CHANNELS];
    logic [W-1:0]            ch_data [NUM_CHANNELS];

    assign ch_wclk  = {clk_b, clk_a};
    assign ch_rclk  = {clk_a, clk_b};
    assign ch_wfire = {b_mb_write, a_mb_write};
    assign ch_rfire = {a_mb_read, b_mb_read};
    assign ch_din[0] = a_din;
    assign ch_din[1] = b_din;

    genvar c;
    generate
        for (c = 0; c < NUM_CHANNELS; c++) begin : g_ch
            mbox_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
                .wclk    (ch_wclk[c]),
                .rclk    (ch_rclk[c]),
                .rst_n   (rst_n),
                .wr_fire (ch_wfire[c]),
                .din     (ch_din[c]),
                .rd_fire (ch_rfire[c]),
                .flag_n  (ch_flag_n[c]),
                .data_q  (ch_data[c])
            );
        end
    endgenerate

    assign m1_flag_n = ch_flag_n[0];
    assign m2_flag_n = ch_flag_n[1];
    assign a_dout    = ch_data[1];
    assign b_dout    = b_mb ? ch_data[0] : b_fifo_q;
endmodule

// File: tb/sim_xdom_mailbox.sv
module sim_xdom_mailbox;
    localparam int W = 36;

    logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic a_cs_n = 1'b1, a_en = 1'b0, a_wr = 1'b0, a_mb = 1'b0;
    logic b_cs_n = 1'b1, b_en = 1'b0, b_wr = 1'b0, b_mb = 1'b1;
    logic [W-1:0] a_din = '0, b_din = '0, b_fifo_q = '0;
    logic [W-1:0] a_dout, b_dout;
    logic m1_flag_n, m2_flag_n;

    int vectors = 0;
    int miscompares = 0;
    logic [W-1:0] exp_m1 = '0, exp_m2 = '0;

    always #10 clk_a = ~clk_a;
    always #13 clk_b = ~clk_b;

    xdom_mailbox #(.W(W)) u0 (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_cs_n(a_cs_n), .a_en(a_en), .a_wr(a_wr), .a_mb(a_mb),
        .a_din(a_din), .a_dout(a_dout), .m1_flag_n(m1_flag_n),
        .b_cs_n(b_cs_n), .b_en(b_en), .b_wr(b_wr), .b_mb(b_mb),
        .b_din(b_din), .b_fifo_q(b_fifo_q), .b_dout(b_dout),
        .m2_flag_n(m2_flag_n)
    );

    function automatic logic [W-1:0] pat(input int i);
        logic [63:0] x;
        x = 64'h9E3779B97F4A7C15 * 64'(i + 1) ^ 64'(i * 7);
        return x[W-1:0];
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic a_drive(input logic cs_n, en, wr, mb, input logic [W-1:0] d);
        @(negedge clk_a);
        a_cs_n = cs_n; a_en = en; a_wr = wr; a_mb = mb; a_din = d;
        @(negedge clk_a);
        a_cs_n = 1'b1; a_en = 1'b0;
    endtask

    task automatic b_drive(input logic cs_n, en, wr, mb, input logic [W-1:0] d);
        @(negedge clk_b);
        b_cs_n = cs_n; b_en = en; b_wr = wr; b_mb = mb; b_din = d;
        @(negedge clk_b);
        b_cs_n = 1'b1; b_en = 1'b0; b_mb = 1'b1;
    endtask

    // R5: B reads mail1, flag back high within 8 A cycles
    task automatic clear_m1();
        repeat (5) @(negedge clk_b);
        b_drive(1'b0, 1'b1, 1'b0, 1'b1, '0);
        for (int k = 0; k < 8 && m1_flag_n !== 1'b1; k++) @(negedge clk_a);
        chk("R5 mail1 flag after B read", W'(m1_flag_n), W'(1));
    endtask

    // R8: A reads mail2, flag back high within 8 B cycles
    task automatic clear_m2();
        repeat (5) @(negedge clk_a);
        a_drive(1'b0, 1'b1, 1'b0, 1'b1, '0);
        for (int k = 0; k < 8 && m2_flag_n !== 1'b1; k++) @(negedge clk_b);
        chk("R8 mail2 flag after A read", W'(m2_flag_n), W'(1));
    endtask

    initial begin
        #4000000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk_b);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_a);

        // R1 reset state
        chk("R1 m1 flag", W'(m1_flag_n), W'(1));
        chk("R1 m2 flag", W'(m2_flag_n), W'(1));
        chk("R1 mail1 word", b_dout, '0);
        chk("R1 mail2 word", a_dout, '0);

        // R2/R3/R4: all port-A control combinations
        for (int c = 0; c < 16; c++) begin
            logic hit;
            hit = (c == 4'b0111);
            a_drive(c[3], c[2], c[1], c[0], pat(c));
            if (hit) exp_m1 = pat(c);
            chk(hit ? "R2 flag after write" : "R3 flag unqualified", W'(m1_flag_n), W'(!hit));
            chk(hit ? "R2 mail1 word" : "R3 mail1 word", b_dout, exp_m1);
            if (hit) begin
                a_drive(1'b0, 1'b1, 1'b1, 1'b1, ~pat(c));
                chk("R4 word kept on blocked write", b_dout, exp_m1);
                chk("R4 flag kept low", W'(m1_flag_n), W'(0));
                clear_m1();
                a_drive(1'b0, 1'b1, 1'b1, 1'b1, pat(c + 40));
                exp_m1 = pat(c + 40);
                chk("R2 rewrite after clear", b_dout, exp_m1);
                clear_m1();
            end
        end

        // R8: all port-B control combinations on mail2
        for (int c = 0; c < 16; c++) begin
            logic hit;
            hit = (c == 4'b0111);
            b_drive(c[3], c[2], c[1], c[0], pat(c + 100));
            if (hit) exp_m2 = pat(c + 100);
            chk("R8 mail2 flag", W'(m2_flag_n), W'(!hit));
            chk("R8 mail2 word", a_dout, exp_m2);
            if (hit) begin
                b_drive(1'b0, 1'b1, 1'b1, 1'b1, ~pat(c));
                chk("R8 blocked write word", a_dout, exp_m2);
                chk("R8 blocked write flag", W'(m2_flag_n), W'(0));
                clear_m2();
            end
        end

        // R6/R9: early read ignored, flag then held low
        begin
            logic held;
            held = 1'b1;
            b_drive(1'b0, 1'b1, 1'b0, 1'b1, '0);
            repeat (4) @(negedge clk_a);
            a_drive(1'b0, 1'b1, 1'b1, 1'b1, pat(77));
            exp_m1 = pat(77);
            for (int k = 0; k < 12; k++) begin
                @(negedge clk_a);
                if (m1_flag_n !== 1'b0) held = 1'b0;
            end
            chk("R6 R9 flag held low", W'(held), W'(1));
            clear_m1();
        end

        // R7: output steering on port B
        for (int i = 0; i < 8; i++) begin
            @(negedge clk_b);
            b_fifo_q = pat(i + 200);
            b_cs_n = i[0]; b_en = i[1]; b_wr = i[2];
            b_mb = 1'b0;
            #1;
            chk("R7 queue word", b_dout, pat(i + 200));
            b_mb = 1'b1;
            #1;
            chk("R7 mailbox word", b_dout, exp_m1);
            b_cs_n = 1'b1; b_en = 1'b0; b_wr = 1'b0;
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule